// File: doc/BRIEF.md
# Half-to-Single Precision Widener

This block takes a 16-bit IEEE-754 binary16 word and produces the binary32 word of exactly the same value. Every binary16 value can be represented in binary32, so the conversion never rounds and the block takes no rounding-mode input. Normal values get a rebiased exponent and a zero-extended fraction. Signed zeros and infinities keep their class. NaNs come out quiet. Subnormal halves are renormalised through a leading-zero count, so they become normal singles and are not flushed to zero.

With the default parameter setting, a single register stage sits behind the combinational datapath. It is qualified by a valid bit and cleared by a synchronous active-high reset. When the parameter is set to zero, the block is purely combinational and `out_valid` simply follows `in_valid`.

Top module: `h2s_widen`

## Requirements
- R1: For an input with a biased exponent from 1 to 30, the output has the same sign, a biased exponent equal to the input exponent plus 112, and the 10 input fraction bits in output bits 22:13.
- R2: An input with exponent 0 and fraction 0 gives a zero output of the same sign: bit 31 equals input bit 15 and bits 30:0 are 0.
- R3: An input with exponent 31 and fraction 0 gives an infinity of the same sign: output exponent 255 and output fraction 0.
- R4: An input with exponent 31 and a nonzero fraction gives a NaN with exponent 255. Output bit 22 is forced to 1, and input fraction bits 8:0 appear in output bits 21:13.
- R5: An input with exponent 0 and a nonzero fraction whose most significant set bit is at position p (0 to 9) gives exponent 103+p. The fraction bits below position p are moved to the top of the output fraction, with the remaining bits zero.
- R6: Output bit 31 always equals input bit 15.
- R7: In the registered variant, the output word and `out_valid` appear one clock after the input is presented with `in_valid` high. While `in_valid` is low, `out_valid` is 0 and `out_single` holds its previous value.
- R8: A synchronous active-high reset clears `out_valid` and `out_single` to 0.
- R9: Output bits 12:0 are always 0, because no binary16 value needs them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_half` as a value to convert |
| in_half | input | 16 | binary16 operand |
| out_valid | output | 1 | Marks `out_single` as a fresh result |
| out_single | output | 32 | binary32 result |

## Verification
The hardest region to reach is the subnormal renormalisation. Each of the ten leading-one positions selects a different shift and a different exponent. A NaN whose only set fraction bit is the top one is also a corner: forcing the quiet bit changes nothing for it, yet it must not turn into an infinity. The bench drives all 65536 input codes back to back, so every leading-one position, every payload and both signs are covered. It then removes `in_valid` to check that the output register holds, and compares each result with a reference model written in the bench that renormalises by repeated doubling.

// File: rtl/fp16w_pkg.sv
package fp16w_pkg;

    localparam int H_EXP_W  = 5;
    localparam int H_FRAC_W = 10;
    localparam int S_EXP_W  = 8;
    localparam int S_FRAC_W = 23;
    localparam int H_W      = 1 + H_EXP_W + H_FRAC_W;
    localparam int S_W      = 1 + S_EXP_W + S_FRAC_W;
    localparam int FRAC_PAD = S_FRAC_W - H_FRAC_W;
    localparam int H_BIAS   = (1 << (H_EXP_W - 1)) - 1;
    localparam int S_BIAS   = (1 << (S_EXP_W - 1)) - 1;
    localparam int REBIAS   = S_BIAS - H_BIAS;
    localparam int LZ_W     = $clog2(H_FRAC_W + 1);

    typedef struct packed {
        logic                sign;
        logic [H_EXP_W-1:0]  exp;
        logic [H_FRAC_W-1:0] frac;
    } half_t;

    typedef struct packed {
        logic                sign;
        logic [S_EXP_W-1:0]  exp;
        logic [S_FRAC_W-1:0] frac;
    } single_t;

    typedef enum logic [2:0] {
        HC_ZERO,
        HC_SUB,
        HC_NORM,
        HC_INF,
        HC_NAN
    } hclass_e;

    function automatic hclass_e classify(input half_t h);
        if (h.exp == '0)
            return (h.frac == '0) ? HC_ZERO : HC_SUB;
        else if (h.exp == '1)
            return (h.frac == '0) ? HC_INF : HC_NAN;
        else
            return HC_NORM;
    endfunction

endpackage

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
    parameter int W  = 10,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end

    // R5: the counted position holds a one and nothing above it is set
    always_comb begin
        if (vec != '0) begin
            a_r5_lead_one: assert (vec[W - 1 - int'(cnt)] == 1'b1);
            a_r5_none_above: assert ((vec >> (W - int'(cnt))) == '0);
        end
    end

endmodule

// File: rtl/h2s_core.sv
module h2s_core
    import fp16w_pkg::*;
(
    input  logic [H_W-1:0] in_half,
    output logic [S_W-1:0] out_single
);

    half_t               h;
    single_t             s;
    hclass_e             cls;
    logic [LZ_W-1:0]     lz;
    logic [H_FRAC_W-1:0] sub_frac;
    logic [S_EXP_W-1:0]  sub_exp;

    assign h   = half_t'(in_half);
    assign cls = classify(h);

    h2s_lzc #(.W(H_FRAC_W), .CW(LZ_W)) u_lzc (
        .vec (h.frac),
        .cnt (lz)
    );

    // shifting past the leading one drops the hidden bit
    assign sub_frac = h.frac << (int'(lz) + 1);
    assign sub_exp  = S_EXP_W'(REBIAS - int'(lz));

    always_comb begin
        s.sign = h.sign;
        s.exp  = '0;
        s.frac = '0;
        unique case (cls)
            HC_ZERO: begin
                s.exp  = '0;
                s.frac = '0;
            end
            HC_SUB: begin
                s.exp  = sub_exp;
                s.frac = {sub_frac, {FRAC_PAD{1'b0}}};
            end
            HC_NORM: begin
                s.exp  = S_EXP_W'(int'(h.exp) + REBIAS);
                s.frac = {h.frac, {FRAC_PAD{1'b0}}};
            end
            HC_INF: begin
                s.exp  = '1;
                s.frac = '0;
            end
            HC_NAN: begin
                s.exp  = '1;
                s.frac = {1'b1, h.frac[H_FRAC_W-2:0], {FRAC_PAD{1'b0}}};
            end
            default: begin
                s.exp  = '0;
                s.frac = '0;
            end
        endcase
    end

    assign out_single = s;

    // R6 and R9 on the combinational result
    always_comb begin
        a_r6_sign_kept: assert (out_single[S_W-1] == in_half[H_W-1]);
        a_r9_low_zero: assert (out_single[FRAC_PAD-1:0] == '0);
    end

endmodule

// File: rtl/h2s_widen.sv
module h2s_widen
    import fp16w_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] in_half,
    output logic        out_valid,
    output logic [31:0] out_single
);

    logic [S_W-1:0] conv;

    h2s_core u_core (
        .in_half    (in_half),
        .out_single (conv)
    );

    generate
        if (REGISTERED) begin : g_reg
            logic           vld_q;
            logic [S_W-1:0] data_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q  <= 1'b0;
                    data_q <= '0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) data_q <= conv;
                end
            end

            assign out_valid  = vld_q;
            assign out_single = data_q;

            a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            a_r7_valid_fall: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            a_r7_hold: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(out_single));
            a_r6_sign_reg: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_single[31] == $past(in_half[15]));
            a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
                (out_valid && out_single[30:23] == 8'hFF && out_single[22:0] != '0)
                |-> out_single[22]);
            a_r8_cleared: assert property (@(posedge clk)
                rst |=> (!out_valid && out_single == '0));
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign out_single = conv;
        end
    endgenerate

endmodule

// File: tb/test_h2s_widen.sv
`timescale 1ns/1ps
module test_h2s_widen;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_half;
    logic        out_valid;
    logic [31:0] out_single;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    h2s_widen i_h2s_widen (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_half    (in_half),
        .out_valid  (out_valid),
        .out_single (out_single)
    );

    function automatic logic [31:0] model(input logic [15:0] h);
        logic       sg;
        int         e;
        logic [10:0] m;
        int         ex;
        sg = h[15];
        e  = int'(h[14:10]);
        m  = {1'b0, h[9:0]};
        if (e == 31) begin
            if (m == 0) return {sg, 8'hFF, 23'd0};
            return {sg, 8'hFF, 1'b1, h[8:0], 13'd0};
        end
        if (e == 0) begin
            if (m == 0) return {sg, 31'd0};
            ex = -14;
            while (m[10] == 1'b0) begin
                m  = m * 2;
                ex = ex - 1;
            end
            return {sg, 8'(ex + 127), m[9:0], 13'd0};
        end
        return {sg, 8'(e + 112), h[9:0], 13'd0};
    endfunction

    function automatic string tag(input logic [15:0] h);
        if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R3" : "R4";
        if (h[14:10] == 5'd0)  return (h[9:0] == 0) ? "R2" : "R5";
        return "R1";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        logic [15:0] prev;
        logic [31:0] hold_val;
        rst      = 1'b1;
        in_valid = 1'b1;
        in_half  = 16'h3C00;
        repeat (3) @(negedge clk);
        // R8: reset clears both outputs even with a valid input present
        check("R8 out_valid", {31'd0, out_valid}, 32'd0);
        check("R8 out_single", out_single, 32'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R7 idle valid", {31'd0, out_valid}, 32'd0);
        // exhaustive sweep, one code per clock
        in_valid = 1'b1;
        in_half  = 16'h0000;
        prev     = 16'h0000;
        for (int c = 1; c <= 65536; c++) begin
            @(negedge clk);
            check({tag(prev), " value"}, out_single, model(prev));
            check("R7 valid", {31'd0, out_valid}, 32'd1);
            check("R6 sign", {31'd0, out_single[31]}, {31'd0, prev[15]});
            check("R9 low bits", {19'd0, out_single[12:0]}, 32'd0);
            if (c < 65536) begin
                in_half = 16'(c);
                prev    = 16'(c);
            end
        end
        // R7: no valid, output holds
        hold_val = out_single;
        in_valid = 1'b0;
        in_half  = 16'h7E00;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R7 hold data", out_single, hold_val);
            check("R7 hold valid", {31'd0, out_valid}, 32'd0);
        end
        // R4 corner: quiet NaN with only top fraction bit set, negative
        in_valid = 1'b1;
        in_half  = 16'hFE00;
        @(negedge clk);
        check("R4 top-bit NaN", out_single, 32'hFFC00000);
        // R5 smallest and largest subnormals
        in_half = 16'h0001;
        @(negedge clk);
        check("R5 min subnormal", out_single, 32'h33800000);
        in_half = 16'h83FF;
        @(negedge clk);
        check("R5 max subnormal", out_single, 32'hB87FC000);
        // R8: reset mid-stream
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid reset data", out_single, 32'd0);
        check("R8 mid reset valid", {31'd0, out_valid}, 32'd0);
        rst = 1'b0;
        done = 1'b1;
        finish_run();
    end

    initial begin
        for (int t = 0; t < 150000; t++) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule